// File: doc/BRIEF.md
# Per-channel configuration register banks

This block keeps the per-channel settings of a two-channel receiver in a small set of write-only register banks. A host writes a bank over a parallel port: it places a 3-bit bank address and a 7-bit data word on the port and pulls an active-low write strobe low. Each bank is 7 bits wide.

Every channel owns three banks at consecutive addresses: two static banks and one dynamic bank. The two channels are five addresses apart, so the first channel uses addresses 0 to 2 and the second uses addresses 5 to 7. Addresses 3 and 4 are internal test banks. They accept data, but no control output depends on them.

From the stored bits the block drives each channel's controls:
- the receive self-test enable;
- the receive PLL power-down flag;
- two serial output enables;
- two reclocker output enables;
- two derived flags. One powers down the channel's internal logic when both serial drivers are off. The other turns off the reclocker when both reclocker drivers are off, and it leaves the other outputs alone.

Top module: `cfg_latch_banks`

## Requirements
- R1: The banks of channel c sit at addresses 5*c, 5*c+1 and 5*c+2. Offset 1 is the output-enable static bank and offset 2 is the dynamic bank, so channel 0 uses addresses 0..2 and channel 1 uses addresses 5..7.
- R2: A bank takes `cfg_data` on every rising clock edge at which `cfg_wr_n` is 0 and `cfg_addr` selects it. While `cfg_wr_n` is 1, no bank and no output changes. A strobe held low for several cycles rewrites the same value.
- R3: In the dynamic bank, bit 0 drives `rx_bist_en` directly. Bit 1 is the PLL-on bit, and `rx_pll_pwrdn` is 1 exactly when that bit is 0.
- R4: In the output-enable static bank, bits 0, 1, 2 and 3 drive `ser_oe1`, `ser_oe2`, `rclk_oe1` and `rclk_oe2` in that order.
- R5: A write to address 3 or 4 changes no output of either channel.
- R6: After reset, `rx_bist_en` is 0 and `rx_pll_pwrdn` is 1 for both channels. The four output enables are 1, and `ch_logic_pwrdn` and `rclk_off` are 0.
- R7: `ch_logic_pwrdn` of a channel is 1 exactly when both of its serial output enables are 0.
- R8: `rclk_off` of a channel is 1 exactly when both of its reclocker enables are 0. Clearing the reclocker enables leaves the serial enables and `ch_logic_pwrdn` unchanged.
- R9: A write to one channel's bank leaves every output of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 3 | Bank address |
| cfg_data | input | 7 | Write data |
| cfg_wr_n | input | 1 | Active-low write strobe |
| rx_bist_en | output | 2 | Receive self-test enable, one bit per channel |
| rx_pll_pwrdn | output | 2 | Receive PLL and analog path powered down |
| ser_oe1 | output | 2 | First serial output enable |
| ser_oe2 | output | 2 | Second serial output enable |
| rclk_oe1 | output | 2 | First reclocker output enable |
| rclk_oe2 | output | 2 | Second reclocker output enable |
| ch_logic_pwrdn | output | 2 | Channel internal logic powered down |
| rclk_off | output | 2 | Reclocker function disabled |

## Verification
The bench writes walking and complementary patterns into each channel's dynamic bank and output-enable bank. These patterns show whether a bit has moved to the wrong position and whether the PLL flag has the wrong polarity. It then steps the enables through all four on/off pairs, which separates an AND of the two enables from an OR or from a single bit.

Further writes check the address map itself. Writes to the test addresses, writes to the other channel, and strobe-high cycles carrying different data each show whether decoding leaks into a neighbouring address or an idle cycle. A long low strobe and a mid-run reset check the capture timing and the reset values.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   // Bank offsets inside a channel's group
   localparam int BANKS_PER_CH = 3;
   localparam int OFS_STAT0    = 0;
   localparam int OFS_OE       = 1;
   localparam int OFS_DYN      = 2;

   // Bit positions in the dynamic bank
   localparam int DYN_BIST_BIT = 0;
   localparam int DYN_PLL_BIT  = 1;

   // Bit positions in the output-enable static bank
   localparam int OE_SER1_BIT  = 0;
   localparam int OE_SER2_BIT  = 1;
   localparam int OE_RCK1_BIT  = 2;
   localparam int OE_RCK2_BIT  = 3;

   typedef struct packed {
      logic bist_en;
      logic pll_pwrdn;
      logic ser_oe1;
      logic ser_oe2;
      logic rclk_oe1;
      logic rclk_oe2;
      logic logic_pwrdn;
      logic rclk_off;
   } chan_ctrl_t;

   function automatic int chan_base(input int ch, input int stride);
      return ch * stride;
   endfunction

   function automatic bit addr_mapped(input int a, input int stride, input int nch);
      for (int c = 0; c < nch; c++)
         if (a >= chan_base(c, stride) && a < chan_base(c, stride) + BANKS_PER_CH)
            return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] bank_reset(input int a, input int stride,
                                              input int nch, input logic [31:0] oe_rst);
      for (int c = 0; c < nch; c++)
         if (a == chan_base(c, stride) + OFS_OE)
            return oe_rst;
      return 32'd0;
   endfunction
endpackage

// File: rtl/cfg_bank.sv
module cfg_bank #(
   parameter int             DW  = 7,
   parameter logic [DW-1:0]  RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST;
      else if (we)
         q <= d;
   end

   // R2: an unselected bank keeps its contents
   a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
   // R2: a selected bank takes the data of that edge
   a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q == $past(d));
endmodule

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
   parameter int ADDR_W = 3,
   localparam int N_ADDR = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_n,
   output logic [N_ADDR-1:0] we_vec
);
   for (genvar a = 0; a < N_ADDR; a++) begin : g_we
      assign we_vec[a] = !wr_n && (addr == ADDR_W'(a));
   end
endmodule

// File: rtl/cfg_chan_ctrl.sv
module cfg_chan_ctrl
   import cfg_pkg::*;
#(
   parameter int DW = 7
) (
   input  logic [DW-1:0] dyn_q,
   input  logic [DW-1:0] oe_q,
   output chan_ctrl_t    ctrl
);
   always_comb begin
      ctrl.bist_en     = dyn_q[DYN_BIST_BIT];
      ctrl.pll_pwrdn   = !dyn_q[DYN_PLL_BIT];
      ctrl.ser_oe1     = oe_q[OE_SER1_BIT];
      ctrl.ser_oe2     = oe_q[OE_SER2_BIT];
      ctrl.rclk_oe1    = oe_q[OE_RCK1_BIT];
      ctrl.rclk_oe2    = oe_q[OE_RCK2_BIT];
      ctrl.logic_pwrdn = !(oe_q[OE_SER1_BIT] || oe_q[OE_SER2_BIT]);
      ctrl.rclk_off    = !(oe_q[OE_RCK1_BIT] || oe_q[OE_RCK2_BIT]);
   end
endmodule

// File: rtl/cfg_latch_banks.sv
module cfg_latch_banks
   import cfg_pkg::*;
#(
   parameter int             N_CH      = 2,
   parameter int             ADDR_W    = 3,
   parameter int             DW        = 7,
   parameter int             CH_STRIDE = 5,
   parameter logic [DW-1:0]  OE_RST    = 'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DW-1:0]     cfg_data,
   input  logic              cfg_wr_n,
   output logic [N_CH-1:0]   rx_bist_en,
   output logic [N_CH-1:0]   rx_pll_pwrdn,
   output logic [N_CH-1:0]   ser_oe1,
   output logic [N_CH-1:0]   ser_oe2,
   output logic [N_CH-1:0]   rclk_oe1,
   output logic [N_CH-1:0]   rclk_oe2,
   output logic [N_CH-1:0]   ch_logic_pwrdn,
   output logic [N_CH-1:0]   rclk_off
);
   localparam int N_ADDR  = 1 << ADDR_W;
   localparam int TOP_USE = chan_base(N_CH - 1, CH_STRIDE) + BANKS_PER_CH;

   // Elaboration-time parameter checks
   if (DW < 4) begin : g_bad_dw
      $error("cfg_latch_banks: DW must hold the four output-enable bits");
   end
   if (CH_STRIDE < BANKS_PER_CH) begin : g_bad_stride
      $error("cfg_latch_banks: channel groups overlap");
   end
   if (TOP_USE > N_ADDR) begin : g_bad_addr
      $error("cfg_latch_banks: address space too small for the channel count");
   end

   logic [N_ADDR-1:0] we_vec;
   logic [DW-1:0]     bank_q [N_ADDR];
   chan_ctrl_t        ctrl   [N_CH];

   cfg_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
      .addr   (cfg_addr),
      .wr_n   (cfg_wr_n),
      .we_vec (we_vec)
   );

   // One bank per address; unmapped addresses become the test banks
   for (genvar a = 0; a < N_ADDR; a++) begin : g_bank
      localparam logic [31:0] RV = bank_reset(a, CH_STRIDE, N_CH, 32'(OE_RST));
      cfg_bank #(.DW(DW), .RST(RV[DW-1:0])) i_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (we_vec[a]),
         .d     (cfg_data),
         .q     (bank_q[a])
      );
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam int BASE = chan_base(c, CH_STRIDE);
      localparam logic [ADDR_W-1:0] A_DYN = ADDR_W'(BASE + OFS_DYN);
      localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(BASE + OFS_OE);

      cfg_chan_ctrl #(.DW(DW)) i_ctrl (
         .dyn_q (bank_q[BASE + OFS_DYN]),
         .oe_q  (bank_q[BASE + OFS_OE]),
         .ctrl  (ctrl[c])
      );

      assign rx_bist_en[c]     = ctrl[c].bist_en;
      assign rx_pll_pwrdn[c]   = ctrl[c].pll_pwrdn;
      assign ser_oe1[c]        = ctrl[c].ser_oe1;
      assign ser_oe2[c]        = ctrl[c].ser_oe2;
      assign rclk_oe1[c]       = ctrl[c].rclk_oe1;
      assign rclk_oe2[c]       = ctrl[c].rclk_oe2;
      assign ch_logic_pwrdn[c] = ctrl[c].logic_pwrdn;
      assign rclk_off[c]       = ctrl[c].rclk_off;

      // R3: dynamic-bank write reaches the self-test enable and PLL flag
      a_r3_dyn_write: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_wr_n && cfg_addr == A_DYN) |=>
            (rx_bist_en[c] == $past(cfg_data[DYN_BIST_BIT])) &&
            (rx_pll_pwrdn[c] == !$past(cfg_data[DYN_PLL_BIT])));
      // R4: output-enable bank write reaches the four enables
      a_r4_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_wr_n && cfg_addr == A_OE) |=>
            ({rclk_oe2[c], rclk_oe1[c], ser_oe2[c], ser_oe1[c]} == $past(cfg_data[3:0])));
      // R8: the reclocker-off flag never follows a serial-enable-only change
      a_r8_rclk_indep: assert property (@(posedge clk) disable iff (!rst_n)
         $stable({rclk_oe1[c], rclk_oe2[c]}) |-> $stable(rclk_off[c]));
   end

   // R2: idle strobe freezes every output
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_n |=> $stable({rx_bist_en, rx_pll_pwrdn, ser_oe1, ser_oe2,
                            rclk_oe1, rclk_oe2, ch_logic_pwrdn, rclk_off}));
   // R5: test-bank writes are invisible at the outputs
   a_r5_test_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr_n && !addr_mapped(int'(cfg_addr), CH_STRIDE, N_CH)) |=>
         $stable({rx_bist_en, rx_pll_pwrdn, ser_oe1, ser_oe2,
                  rclk_oe1, rclk_oe2, ch_logic_pwrdn, rclk_off}));
endmodule

// File: tb/test_cfg_latch_banks.sv
module test_cfg_latch_banks;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [6:0] cfg_data = '0;
   logic       cfg_wr_n = 1'b1;
   logic [1:0] rx_bist_en, rx_pll_pwrdn, ser_oe1, ser_oe2;
   logic [1:0] rclk_oe1, rclk_oe2, ch_logic_pwrdn, rclk_off;

   int n_chk = 0;
   int n_err = 0;
   logic [6:0] mdl [8];

   always #4 clk = ~clk;

   cfg_latch_banks i_cfg_latch_banks (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .cfg_wr_n(cfg_wr_n), .rx_bist_en(rx_bist_en), .rx_pll_pwrdn(rx_pll_pwrdn),
      .ser_oe1(ser_oe1), .ser_oe2(ser_oe2), .rclk_oe1(rclk_oe1), .rclk_oe2(rclk_oe2),
      .ch_logic_pwrdn(ch_logic_pwrdn), .rclk_off(rclk_off)
   );

   // Expected {bist, pllpd, oe1, oe2, roe1, roe2, logicpd, rclkoff}
   function automatic logic [7:0] exp_ch(input int c);
      logic [6:0] d = mdl[c*5 + 2];
      logic [6:0] o = mdl[c*5 + 1];
      return {d[0], ~d[1], o[0], o[1], o[2], o[3], ~o[0] & ~o[1], ~o[2] & ~o[3]};
   endfunction

   function automatic logic [7:0] got_ch(input int c);
      return {rx_bist_en[c], rx_pll_pwrdn[c], ser_oe1[c], ser_oe2[c],
              rclk_oe1[c], rclk_oe2[c], ch_logic_pwrdn[c], rclk_off[c]};
   endfunction

   task automatic check_ch(input string tag, input int c);
      n_chk++;
      if (got_ch(c) !== exp_ch(c)) begin
         n_err++;
         $display("FAIL %s ch%0d: actual=%b expected=%b", tag, c, got_ch(c), exp_ch(c));
      end
   endtask

   task automatic check_all(input string tag);
      check_ch(tag, 0);
      check_ch(tag, 1);
   endtask

   task automatic model_reset();
      for (int a = 0; a < 8; a++) mdl[a] = 7'h00;
      mdl[1] = 7'h0F;
      mdl[6] = 7'h0F;
   endtask

   task automatic wr(input logic [2:0] a, input logic [6:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_data = d; cfg_wr_n = 1'b0;
      @(negedge clk);
      cfg_wr_n = 1'b1;
      cfg_data = ~d;
      mdl[a] = d;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic t_reset();
      do_reset();
      check_all("R6 reset state");
   endtask

   task automatic t_dyn_bits();
      logic [6:0] pats [4] = '{7'h01, 7'h02, 7'h03, 7'h7C};
      foreach (pats[i]) begin
         wr(3'd2, pats[i]);
         check_all("R3 dyn ch0");
         wr(3'd7, ~pats[i]);
         check_all("R3 dyn ch1");
      end
   endtask

   task automatic t_oe_pairs();
      for (int s = 0; s < 4; s++) begin
         wr(3'd1, 7'(s) | 7'h0C);
         check_all("R7 serial pair ch0");
      end
      for (int r = 0; r < 4; r++) begin
         wr(3'd6, 7'(r << 2) | 7'h03);
         check_all("R8 reclock pair ch1");
      end
      wr(3'd1, 7'h01); check_all("R4 oe walk bit0");
      wr(3'd1, 7'h02); check_all("R4 oe walk bit1");
      wr(3'd1, 7'h04); check_all("R4 oe walk bit2");
      wr(3'd1, 7'h08); check_all("R4 oe walk bit3");
      wr(3'd6, 7'h0F); check_all("R1 ch1 oe bank");
   endtask

   task automatic t_test_addr();
      wr(3'd2, 7'h03); wr(3'd7, 7'h01);
      wr(3'd1, 7'h05); wr(3'd6, 7'h0A);
      wr(3'd3, 7'h7F); check_all("R5 test addr 3 ones");
      wr(3'd4, 7'h7F); check_all("R5 test addr 4 ones");
      wr(3'd3, 7'h00); wr(3'd4, 7'h00);
      check_all("R5 test addr zeros");
   endtask

   task automatic t_isolation();
      wr(3'd0, 7'h55); check_all("R9 static0 ch0 write");
      wr(3'd5, 7'h2A); check_all("R9 static0 ch1 write");
      wr(3'd2, 7'h01); check_all("R9 ch0 dyn write");
      wr(3'd6, 7'h00); check_all("R9 ch1 oe write");
   endtask

   task automatic t_strobe();
      // idle cycles with changing data
      @(negedge clk);
      cfg_addr = 3'd2; cfg_wr_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         cfg_data = 7'(i * 37);
         @(negedge clk);
      end
      check_all("R2 idle strobe");
      // long low pulse
      cfg_addr = 3'd7; cfg_data = 7'h03; cfg_wr_n = 1'b0;
      @(negedge clk);
      mdl[7] = 7'h03;
      check_all("R2 first cycle of long strobe");
      @(negedge clk);
      @(negedge clk);
      cfg_wr_n = 1'b1;
      check_all("R2 long strobe");
   endtask

   task automatic t_mid_reset();
      wr(3'd2, 7'h03); wr(3'd6, 7'h00);
      do_reset();
      check_all("R6 reset after writes");
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_dyn_bits();
      t_oe_pairs();
      t_test_addr();
      t_isolation();
      t_strobe();
      t_mid_reset();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule